// File: doc/BRIEF.md
# Fractional Rate Clock Enable Generator

This block turns a fast free-running clock into a one-cycle enable strobe whose average rate is a fraction of that clock. The fraction is given by a numerator and a denominator. With the usual setting of 78 over 100, a 100 MHz clock yields an enable that is high on 78 of every 100 cycles, which gives an effective 78 MHz rate. No integer divider can reach that rate. The cycles without a strobe are spread out, so no two of them are ever adjacent.

The rate comes from a phase accumulator. On each cycle it adds the numerator, and whenever the sum reaches the denominator it wraps and raises the enable. The ratio is captured while reset is held and stays fixed after release. The enable comes straight from a flip-flop. It is meant to qualify logic on the same clock, for example as the base tick of an oversampling serial receiver. It has one input period of jitter and no defined duty cycle.

Top module: `frac_en_gen`

## Requirements
- R1: While `rst` is high, `en_o` is low from the first clock edge onward, and the accumulator returns to zero.
- R2: `num_i` and `den_i` are captured only on edges where `rst` is high. Changing them after release has no effect on `en_o`.
- R3: On each edge out of reset with 0 < num < den, the accumulator adds num. If the sum is at least den, den is subtracted and the enable for that step is 1. `en_o` shows that step's result one edge later, and the accumulator always stays below den.
- R4: With num = 78 and den = 100, every run of 100 consecutive output cycles after release holds exactly 78 high cycles.
- R5: Whenever 2*num >= den, no two consecutive output cycles are both low. For 78/100, the distance between successive low cycles is always 4 or 5.
- R6: A nonzero num that is greater than or equal to den (den = 0 included) makes `en_o` high on every cycle after release.
- R7: num = 0 keeps `en_o` low permanently, whatever den is.
- R8: For any 0 < num < den, every run of den consecutive output cycles after release holds exactly num high cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast reference clock |
| rst | input | 1 | Synchronous active-high reset, also the ratio load strobe |
| num_i | input | W (8) | Ratio numerator, sampled during reset |
| den_i | input | W (8) | Ratio denominator, sampled during reset |
| en_o | output | 1 | Registered clock-enable strobe |

## Verification
The checker assumes that reset is asserted before the first meaningful edge, so that the ratio registers hold defined values. It also assumes that any new ratio is presented only together with reset. The spacing and saturation properties are only trusted once the enable reflects at least one full step since release, and a small counter in the checker tracks that. The stimulus always reloads the ratio through a fresh reset of at least two edges. It then deliberately moves the inputs right after release, which exercises the hold behaviour without breaking the first assumption.

// File: rtl/frac_en_pkg.sv
package frac_en_pkg;

    // Default width of the ratio operands.
    localparam int RW = 8;

    // Operating mode decoded once from the captured ratio.
    typedef enum logic [1:0] {
        FE_IDLE  = 2'd0,   // numerator zero: strobe never fires
        FE_EVERY = 2'd1,   // numerator >= denominator: strobe every cycle
        FE_FRAC  = 2'd2    // proper fraction: accumulate and wrap
    } fe_mode_e;

    // Width-independent classification of a ratio.
    function automatic fe_mode_e fe_classify(input int unsigned n, input int unsigned d);
        if (n == 0)
            return FE_IDLE;
        else if (n >= d)
            return FE_EVERY;
        else
            return FE_FRAC;
    endfunction

endpackage

// File: rtl/frac_ratio_reg.sv
module frac_ratio_reg
    import frac_en_pkg::*;
#(
    parameter int W = RW
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] num_i,
    input  logic [W-1:0] den_i,
    output logic [W-1:0] num_q,
    output logic [W-1:0] den_q,
    output fe_mode_e     mode_q
);

    typedef struct packed {
        logic [W-1:0] num;
        logic [W-1:0] den;
        fe_mode_e     mode;
    } cfg_t;

    cfg_t cfg_q;
    cfg_t cfg_d;

    always_comb begin
        cfg_d.num  = num_i;
        cfg_d.den  = den_i;
        cfg_d.mode = fe_classify(int'(num_i), int'(den_i));
    end

    // Ratio is loaded only while reset is held, held otherwise.
    always_ff @(posedge clk) begin
        if (rst)
            cfg_q <= cfg_d;
    end

    assign num_q  = cfg_q.num;
    assign den_q  = cfg_q.den;
    assign mode_q = cfg_q.mode;

endmodule

// File: rtl/frac_phase_acc.sv
module frac_phase_acc
    import frac_en_pkg::*;
#(
    parameter int W = RW
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] num,
    input  logic [W-1:0] den,
    input  fe_mode_e     mode,
    output logic         hit,
    output logic [W-1:0] acc_q
);

    localparam int SW = W + 1;

    typedef struct packed {
        logic         hit;
        logic [W-1:0] acc;
    } step_t;

    logic [SW-1:0] sum;
    logic [SW-1:0] wrapped;
    logic          reach;
    step_t         nxt;

    assign sum     = {1'b0, acc_q} + {1'b0, num};
    assign reach   = (sum >= {1'b0, den});
    assign wrapped = sum - {1'b0, den};

    always_comb begin
        unique case (mode)
            FE_EVERY: begin
                nxt.hit = 1'b1;
                nxt.acc = '0;
            end
            FE_FRAC: begin
                nxt.hit = reach;
                nxt.acc = reach ? wrapped[W-1:0] : sum[W-1:0];
            end
            default: begin
                nxt.hit = 1'b0;
                nxt.acc = acc_q;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            acc_q <= '0;
        else
            acc_q <= nxt.acc;
    end

    // During reset the step result is forced inactive.
    assign hit = nxt.hit & ~rst;

endmodule

// File: rtl/frac_strobe_reg.sv
module frac_strobe_reg (
    input  logic clk,
    input  logic rst,
    input  logic hit,
    output logic en_q
);

    // Output taken straight from a flop: glitch-free enable.
    always_ff @(posedge clk) begin
        if (rst)
            en_q <= 1'b0;
        else
            en_q <= hit;
    end

endmodule

// File: rtl/frac_en_gen.sv
module frac_en_gen
    import frac_en_pkg::*;
#(
    parameter int W = RW
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] num_i,
    input  logic [W-1:0] den_i,
    output logic         en_o
);

    logic [W-1:0] num_q;
    logic [W-1:0] den_q;
    fe_mode_e     mode_q;
    logic [W-1:0] acc_q;
    logic         step_hit;

    frac_ratio_reg #(.W(W)) u_ratio (
        .clk    (clk),
        .rst    (rst),
        .num_i  (num_i),
        .den_i  (den_i),
        .num_q  (num_q),
        .den_q  (den_q),
        .mode_q (mode_q)
    );

    frac_phase_acc #(.W(W)) u_acc (
        .clk   (clk),
        .rst   (rst),
        .num   (num_q),
        .den   (den_q),
        .mode  (mode_q),
        .hit   (step_hit),
        .acc_q (acc_q)
    );

    frac_strobe_reg u_out (
        .clk  (clk),
        .rst  (rst),
        .hit  (step_hit),
        .en_q (en_o)
    );

endmodule

// File: rtl/frac_en_gen_chk.sv
module frac_en_gen_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic [W-1:0] num_q,
    input logic [W-1:0] den_q,
    input logic [W-1:0] acc_q,
    input logic         en_o
);

    // Edges since reset release, saturating; seen marks the first edge.
    logic [1:0] live = 2'd0;
    logic       seen = 1'b0;

    always_ff @(posedge clk) begin
        seen <= 1'b1;
        if (rst)
            live <= 2'd0;
        else if (live != 2'd3)
            live <= live + 2'd1;
    end

    logic       frac_mode;
    logic       sparse;
    logic [W:0] twice_num;

    assign twice_num = {num_q, 1'b0};
    assign frac_mode = (num_q != '0) && (num_q < den_q);
    assign sparse    = (num_q != '0) && (twice_num >= {1'b0, den_q});

    a_r1_low_after_reset: assert property (@(posedge clk)
        (seen && $past(rst)) |-> !en_o);

    a_r2_ratio_held: assert property (@(posedge clk) disable iff (rst)
        (seen && !$past(rst)) |-> ($stable(num_q) && $stable(den_q)));

    a_r3_acc_bound: assert property (@(posedge clk) disable iff (rst)
        (live != 2'd0 && frac_mode) |-> (acc_q < den_q));

    a_r5_no_double_drop: assert property (@(posedge clk) disable iff (rst)
        (live == 2'd3 && sparse && !$past(en_o)) |-> en_o);

    a_r6_full_rate: assert property (@(posedge clk) disable iff (rst)
        (live != 2'd0 && num_q != '0 && num_q >= den_q) |-> en_o);

    a_r7_zero_rate: assert property (@(posedge clk) disable iff (rst)
        (live != 2'd0 && num_q == '0) |-> !en_o);

endmodule

bind frac_en_gen frac_en_gen_chk #(.W(W)) u_chk (
    .clk   (clk),
    .rst   (rst),
    .num_q (num_q),
    .den_q (den_q),
    .acc_q (acc_q),
    .en_o  (en_o)
);

// File: tb/sim_frac_en_gen.sv
`timescale 1ns/1ps
module sim_frac_en_gen;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] num_i = 8'd78;
    logic [7:0] den_i = 8'd100;
    logic       en_o;

    always #2.5 clk = ~clk;

    frac_en_gen #(.W(8)) u0 (
        .clk   (clk),
        .rst   (rst),
        .num_i (num_i),
        .den_i (den_i),
        .en_o  (en_o)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Behavioural reference: ratio latched in reset, running remainder.
    int m_num = 0;
    int m_den = 0;
    int m_rem = 0;
    bit m_en  = 0;
    bit m_live = 0;

    always @(posedge clk) begin
        if (rst) begin
            m_num = num_i;
            m_den = den_i;
            m_rem = 0;
            m_en  = 0;
        end else if (m_num == 0) begin
            m_en = 0;
        end else if (m_num >= m_den) begin
            m_en = 1;
        end else begin
            m_rem = m_rem + m_num;
            if (m_rem >= m_den) begin
                m_rem = m_rem - m_den;
                m_en  = 1;
            end else begin
                m_en = 0;
            end
        end
        m_live = 1;
    end

    // R3: cycle-by-cycle comparison against the model.
    always @(negedge clk) begin
        if (m_live && !done)
            check(en_o === m_en, "R3 model compare", int'(en_o), int'(m_en));
    end

    bit hist[$];

    task automatic run(input int n, input int d, input int cycles, input int an, input int ad);
        @(negedge clk);
        rst   = 1'b1;
        num_i = 8'(n);
        den_i = 8'(d);
        repeat (2) @(negedge clk);
        check(en_o == 1'b0, "R1 low during reset", int'(en_o), 0);
        rst   = 1'b0;
        num_i = 8'(an);
        den_i = 8'(ad);
        hist.delete();
        repeat (cycles) begin
            @(negedge clk);
            hist.push_back(en_o);
        end
    endtask

    function automatic int ones(input int from, input int len);
        int s = 0;
        for (int i = from; i < from + len; i++) s += int'(hist[i]);
        return s;
    endfunction

    task automatic window_check(input string req, input int len, input int exp);
        for (int w = 0; w + len <= hist.size(); w += len)
            check(ones(w, len) == exp, req, ones(w, len), exp);
    endtask

    task automatic gap_check(input string req, input int lo, input int hi);
        int last = -1;
        for (int i = 0; i < hist.size(); i++) begin
            if (!hist[i]) begin
                if (last >= 0)
                    check((i - last) >= lo && (i - last) <= hi, req, i - last, lo);
                last = i;
            end
        end
    endtask

    initial begin
        @(negedge clk);
        check(en_o == 1'b0, "R1 reset state", int'(en_o), 0);

        // R4 / R2 / R5: 78 over 100, inputs moved right after release
        run(78, 100, 300, 0, 1);
        window_check("R4 78 per 100 window", 100, 78);
        check(ones(37, 100) == 78, "R4 unaligned window", ones(37, 100), 78);
        check(ones(0, 300) == 234, "R2 inputs ignored after release", ones(0, 300), 234);
        gap_check("R5 drop spacing 4..5", 4, 5);

        // R6: saturated rates
        run(5, 5, 40, 5, 5);
        check(ones(0, 40) == 40, "R6 num equal den", ones(0, 40), 40);
        run(200, 9, 40, 200, 9);
        check(ones(0, 40) == 40, "R6 num above den", ones(0, 40), 40);
        run(7, 0, 20, 7, 0);
        check(ones(0, 20) == 20, "R6 den zero", ones(0, 20), 20);

        // R7: zero numerator
        run(0, 100, 100, 0, 100);
        check(ones(0, 100) == 0, "R7 zero num", ones(0, 100), 0);
        run(0, 0, 30, 0, 0);
        check(ones(0, 30) == 0, "R7 zero num zero den", ones(0, 30), 0);

        // R8: other proper fractions
        run(3, 7, 70, 3, 7);
        window_check("R8 3 per 7", 7, 3);
        run(1, 2, 20, 1, 2);
        window_check("R8 1 per 2", 2, 1);
        gap_check("R5 half rate spacing", 2, 2);
        run(250, 251, 502, 250, 251);
        window_check("R8 250 per 251", 251, 250);

        // R1: reset from a running state
        run(5, 5, 4, 5, 5);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check(en_o == 1'b0, "R1 low after reset edge", int'(en_o), 0);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            done = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule